// File: doc/BRIEF.md
# Reservation Monitor for Linked-Load / Conditional-Store Pairs

This block sits between several processor request ports and a small shared word memory. It gives those ports a way to build atomic read-modify-write sequences out of two separate operations. A linked load returns a memory word and opens a reservation on that word for the issuing port. A conditional store later writes the word only if that reservation is still intact, and it tells the port whether the write happened. Software wraps the pair in a retry loop that branches back when the result is zero.

The monitor sees every write to the memory and every context-switch strobe. It drops any reservation that a write or a switch could have made unsafe. A fixed-priority arbiter grants one request per cycle. The lowest-numbered requesting port wins, and the other ports hold their requests until they are granted. A response comes back on the cycle after the grant.

Top module: `llsc_monitor`

## Requirements
- R1: After reset there is no grant and no response, every memory word reads as zero, and no port holds a reservation, so a conditional store fails.
- R2: Each port's request uses the operation code in `req_op`: 2'b00 plain load, 2'b01 plain store, 2'b10 linked load, 2'b11 conditional store. In every cycle `req_grant` is one-hot or zero. It goes combinationally to the lowest-indexed port whose `req_valid` is high.
- R3: The cycle after a grant, `rsp_valid` has exactly the bit of the granted port set. `rsp_data` carries the word read for a plain or linked load and zero for either kind of store.
- R4: A plain store writes its word. A plain load returns the stored word, whichever port issues it.
- R5: A linked load returns the addressed word, sets the issuing port's reservation and records the address.
- R6: A conditional store writes only when the issuer holds a reservation whose recorded address equals the store address. `rsp_sc_ok` is 1 when the write happened and 0 when it did not. On failure the memory is unchanged.
- R7: Any conditional store clears the issuer's reservation, so a second one with no new linked load fails.
- R8: A plain store or a successful conditional store by another port clears every reservation on that address. Writes by other ports to other addresses, the holder's own plain store, and failed conditional stores leave the reservation in place.
- R9: A `ctx_switch` pulse on a port clears that port's reservation and no other. It wins over a linked load or conditional store from the same port in the same cycle, so that conditional store fails and that linked load leaves no reservation.
- R10: When two ports issue conditional stores to the same reserved word in one cycle, the granted port succeeds. The other port fails when it is granted later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request present, one bit per port |
| req_op | input | 2*NPORTS | Operation code per port |
| req_addr | input | ADDR_W*NPORTS | Word address per port |
| req_wdata | input | DATA_W*NPORTS | Store data per port |
| ctx_switch | input | NPORTS | Context-switch strobe per port |
| req_grant | output | NPORTS | Combinational one-hot grant |
| rsp_valid | output | NPORTS | Response strobe for the port granted last cycle |
| rsp_data | output | DATA_W | Load data, zero for stores |
| rsp_sc_ok | output | 1 | Conditional-store result, 1 for success |

## Verification
The assertions assume that a requester holds its request steady until it sees its grant. They also assume that `ctx_switch` is a single-cycle strobe that needs no grant. The stimulus drives each request for one granted cycle, or it keeps a losing request up until its grant arrives. Context pulses are applied either alone or together with a single request. The sweeps run over every port, every address and every ordered pair of ports. Expected words and result bits come from a bench model that follows the requirements.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LINK  = 2'b10,
      OP_COND  = 2'b11
   } llsc_op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
   parameter int N    = 4,
   localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   output logic [N-1:0]    grant,
   output logic [IDXW-1:0] idx,
   output logic            any
);
   logic [IDXW-1:0] sel;
   logic            hit;

   // Lowest index wins: scan downward so the last hit is the smallest.
   always_comb begin
      sel = '0;
      hit = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            sel = IDXW'(i);
            hit = 1'b1;
         end
      end
   end

   assign idx   = sel;
   assign any   = hit;
   assign grant = hit ? (N'(1) << sel) : '0;

   p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_grant_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   p_grant_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|grant));
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctx,
   input  logic          link_set,
   input  logic          cond_done,
   input  logic          snoop_we,
   input  logic [AW-1:0] snoop_addr,
   input  logic [AW-1:0] link_addr,
   output logic          held,
   output logic [AW-1:0] held_addr
);
   logic          flag_q;
   logic [AW-1:0] addr_q;
   logic          flag_d;

   // Ordering: switch beats everything, then a new link, then the clears.
   always_comb begin
      flag_d = flag_q;
      if (ctx)
         flag_d = 1'b0;
      else if (link_set)
         flag_d = 1'b1;
      else if (cond_done)
         flag_d = 1'b0;
      else if (snoop_we && (snoop_addr == addr_q))
         flag_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         addr_q <= '0;
      end else begin
         flag_q <= flag_d;
         if (link_set)
            addr_q <= link_addr;
      end
   end

   assign held      = flag_q;
   assign held_addr = addr_q;

   p_ctx_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctx |=> !held);
   p_cond_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cond_done |=> !held);
   p_snoop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (held && snoop_we && !link_set && snoop_addr == held_addr) |=> !held);
endmodule

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
   parameter int AW = 3,
   parameter int DW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
   parameter int NPORTS = 4,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   localparam int IDXW  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPORTS-1:0]          req_valid,
   input  logic [2*NPORTS-1:0]        req_op,
   input  logic [ADDR_W*NPORTS-1:0]   req_addr,
   input  logic [DATA_W*NPORTS-1:0]   req_wdata,
   input  logic [NPORTS-1:0]          ctx_switch,
   output logic [NPORTS-1:0]          req_grant,
   output logic [NPORTS-1:0]          rsp_valid,
   output logic [DATA_W-1:0]          rsp_data,
   output logic                       rsp_sc_ok
);
   import llsc_pkg::*;

   if (NPORTS < 2) begin : g_bad_ports
      $error("llsc_monitor: NPORTS must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("llsc_monitor: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("llsc_monitor: DATA_W must be positive");
   end

   llsc_op_e             op_a    [NPORTS];
   logic [ADDR_W-1:0]    addr_a  [NPORTS];
   logic [DATA_W-1:0]    wdata_a [NPORTS];
   logic [NPORTS-1:0]    held;
   logic [ADDR_W-1:0]    held_addr [NPORTS];

   for (genvar gp = 0; gp < NPORTS; gp++) begin : g_unpack
      assign op_a[gp]    = llsc_op_e'(req_op[gp*2 +: 2]);
      assign addr_a[gp]  = req_addr[gp*ADDR_W +: ADDR_W];
      assign wdata_a[gp] = req_wdata[gp*DATA_W +: DATA_W];
   end

   logic [IDXW-1:0] gidx;
   logic            gany;

   llsc_prio_arb #(.N(NPORTS)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_valid),
      .grant (req_grant),
      .idx   (gidx),
      .any   (gany)
   );

   llsc_op_e          sel_op;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   logic              fire_load, fire_store, fire_link, fire_cond;
   logic              cond_ok, mem_we;
   logic [DATA_W-1:0] mem_rdata;

   assign sel_op    = op_a[gidx];
   assign sel_addr  = addr_a[gidx];
   assign sel_wdata = wdata_a[gidx];

   assign fire_load  = gany && (sel_op == OP_LOAD);
   assign fire_store = gany && (sel_op == OP_STORE);
   assign fire_link  = gany && (sel_op == OP_LINK);
   assign fire_cond  = gany && (sel_op == OP_COND);

   // Conditional store succeeds only on an intact, matching reservation.
   assign cond_ok = fire_cond && held[gidx] && !ctx_switch[gidx]
                    && (held_addr[gidx] == sel_addr);
   assign mem_we  = fire_store || cond_ok;

   for (genvar gs = 0; gs < NPORTS; gs++) begin : g_slot
      llsc_resv_slot #(.AW(ADDR_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctx        (ctx_switch[gs]),
         .link_set   (fire_link && req_grant[gs]),
         .cond_done  (fire_cond && req_grant[gs]),
         .snoop_we   (mem_we && !req_grant[gs]),
         .snoop_addr (sel_addr),
         .link_addr  (sel_addr),
         .held       (held[gs]),
         .held_addr  (held_addr[gs])
      );
   end

   llsc_word_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .addr  (sel_addr),
      .wdata (sel_wdata),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_data  <= '0;
         rsp_sc_ok <= 1'b0;
      end else begin
         rsp_valid <= req_grant;
         rsp_data  <= (fire_load || fire_link) ? mem_rdata : '0;
         rsp_sc_ok <= cond_ok;
      end
   end

   p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rsp_valid == $past(req_grant)));
   p_ok_needs_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_sc_ok |-> ($countones(rsp_valid) == 1));
   p_ok_needs_resv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_cond && !held[gidx]) |=> !rsp_sc_ok);
   p_switch_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_cond && ctx_switch[gidx]) |=> !rsp_sc_ok);
endmodule

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
   localparam int NP = 4;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     req_valid = '0;
   logic [2*NP-1:0]   req_op = '0;
   logic [AW*NP-1:0]  req_addr = '0;
   logic [DW*NP-1:0]  req_wdata = '0;
   logic [NP-1:0]     ctx_switch = '0;
   logic [NP-1:0]     req_grant;
   logic [NP-1:0]     rsp_valid;
   logic [DW-1:0]     rsp_data;
   logic              rsp_sc_ok;

   always #4 clk = ~clk;

   llsc_monitor #(.NPORTS(NP), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .ctx_switch(ctx_switch),
      .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_sc_ok(rsp_sc_ok)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [DW-1:0] m_mem  [DEPTH];
   logic          m_flag [NP];
   int            m_addr [NP];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Reference model built from the requirements.
   task automatic model_step(input int p, input logic [1:0] op, input int a,
                             input logic [DW-1:0] d, input logic [NP-1:0] cv,
                             output logic [DW-1:0] ed, output logic eok);
      eok = (op == SC) && m_flag[p] && !cv[p] && (m_addr[p] == a);
      ed  = (op == LD || op == LL) ? m_mem[a] : '0;
      if (op == ST || eok) begin
         m_mem[a] = d;
         for (int q = 0; q < NP; q++)
            if (q != p && m_flag[q] && m_addr[q] == a) m_flag[q] = 1'b0;
      end
      if (op == LL) begin
         m_flag[p] = 1'b1;
         m_addr[p] = a;
      end
      if (op == SC) m_flag[p] = 1'b0;
      for (int q = 0; q < NP; q++)
         if (cv[q]) m_flag[q] = 1'b0;
   endtask

   task automatic drive(input int p, input logic [1:0] op, input int a, input logic [DW-1:0] d);
      req_valid[p] = 1'b1;
      req_op[p*2 +: 2] = op;
      req_addr[p*AW +: AW] = AW'(a);
      req_wdata[p*DW +: DW] = d;
   endtask

   // One request from one port; starts and ends at a falling edge.
   task automatic issue1(input int p, input logic [1:0] op, input int a,
                         input logic [DW-1:0] d, input logic [NP-1:0] cv,
                         input string tag);
      logic [DW-1:0] ed;
      logic eok;
      drive(p, op, a, d);
      ctx_switch = cv;
      #1;
      chk({tag, " grant"}, 32'(req_grant), 32'(1 << p));
      model_step(p, op, a, d, cv, ed, eok);
      @(posedge clk);
      @(negedge clk);
      req_valid = '0;
      ctx_switch = '0;
      chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'(1 << p));
      chk({tag, " data"}, 32'(rsp_data), 32'(ed));
      chk({tag, " sc_ok"}, 32'(rsp_sc_ok), 32'(eok));
   endtask

   task automatic ctx_only(input logic [NP-1:0] cv);
      logic [DW-1:0] ed;
      logic eok;
      ctx_switch = cv;
      for (int q = 0; q < NP; q++) if (cv[q]) m_flag[q] = 1'b0;
      @(posedge clk);
      @(negedge clk);
      ctx_switch = '0;
      ed = '0; eok = 1'b0;
      chk("R9 idle rsp", 32'(rsp_valid), 32'(0));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] ed;
      logic eok;
      for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
      for (int q = 0; q < NP; q++) begin m_flag[q] = 1'b0; m_addr[q] = 0; end

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 grant idle", 32'(req_grant), 32'(0));
      chk("R1 rsp idle", 32'(rsp_valid), 32'(0));
      for (int a = 0; a < DEPTH; a++) issue1(a % NP, LD, a, '0, '0, "R1 zero mem");
      for (int p = 0; p < NP; p++) issue1(p, SC, p, 8'hEE, '0, "R1 no resv");

      // R4 plain store/load across ports
      for (int p = 0; p < NP; p++)
         for (int a = 0; a < DEPTH; a++) begin
            issue1(p, ST, a, DW'((p << 4) ^ a ^ 8'h5A), '0, "R4 store");
            issue1((p + 1) % NP, LD, a, '0, '0, "R4 load");
         end

      // R5 R6 R7 link, conditional, repeat conditional
      for (int p = 0; p < NP; p++)
         for (int a = 0; a < DEPTH; a++) begin
            issue1(p, LL, a, '0, '0, "R5 link");
            issue1(p, SC, a, DW'(8'hA0 + p * 8 + a), '0, "R6 cond ok");
            issue1(p, SC, a, 8'h11, '0, "R7 second cond");
            issue1(p, LD, a, '0, '0, "R6 mem after");
            issue1(p, LL, a, '0, '0, "R5 relink");
            issue1(p, SC, a ^ 1, 8'h33, '0, "R6 addr mismatch");
            issue1(p, LD, a ^ 1, '0, '0, "R6 unchanged");
         end

      // R8 interference between ordered pairs
      for (int p = 0; p < NP; p++)
         for (int q = 0; q < NP; q++) if (q != p) begin
            int a;
            a = (p + q) % DEPTH;
            issue1(p, LL, a, '0, '0, "R8 link");
            issue1(q, ST, a, DW'(p * 16 + q), '0, "R8 foreign store");
            issue1(p, SC, a, 8'h77, '0, "R8 cleared by store");
            issue1(p, LL, a, '0, '0, "R8 link");
            issue1(q, ST, a ^ 2, 8'h44, '0, "R8 other addr");
            issue1(p, SC, a, 8'h78, '0, "R8 survives other addr");
            issue1(p, LL, a, '0, '0, "R8 link");
            issue1(q, SC, a, 8'h99, '0, "R8 failed cond");
            issue1(p, SC, a, 8'h79, '0, "R8 survives failed cond");
            issue1(p, LL, a, '0, '0, "R8 link");
            issue1(p, ST, a, 8'h55, '0, "R8 own store");
            issue1(p, SC, a, 8'h7A, '0, "R8 survives own store");
            issue1(p, LL, a, '0, '0, "R8 link");
            issue1(q, LL, a, '0, '0, "R8 link other");
            issue1(q, SC, a, 8'h66, '0, "R8 other cond ok");
            issue1(p, SC, a, 8'h7B, '0, "R8 cleared by cond");
            issue1(p, LD, a, '0, '0, "R8 final mem");
         end

      // R9 context switches
      for (int p = 0; p < NP; p++) begin
         issue1(p, LL, 5, '0, '0, "R9 link");
         ctx_only(NP'(1 << p));
         issue1(p, SC, 5, 8'hC1, '0, "R9 switch clears");
         issue1(p, LL, 5, '0, NP'(1 << p), "R9 switch with link");
         issue1(p, SC, 5, 8'hC2, '0, "R9 link voided");
         issue1(p, LL, 5, '0, '0, "R9 link");
         issue1(p, SC, 5, 8'hC3, NP'(1 << p), "R9 switch with cond");
         issue1(p, LL, 5, '0, '0, "R9 link");
         ctx_only(~NP'(1 << p));
         issue1(p, SC, 5, 8'hC4, '0, "R9 others switch");
         issue1(p, LD, 5, '0, '0, "R9 mem");
      end

      // R2 R3 simultaneous loads drain in index order
      for (int p = 0; p < NP; p++) drive(p, LD, p, '0);
      for (int k = 0; k < NP; k++) begin
         #1;
         chk("R2 priority grant", 32'(req_grant), 32'(1 << k));
         model_step(k, LD, k, '0, '0, ed, eok);
         @(posedge clk);
         @(negedge clk);
         req_valid[k] = 1'b0;
         chk("R3 rsp port", 32'(rsp_valid), 32'(1 << k));
         chk("R3 rsp data", 32'(rsp_data), 32'(ed));
      end

      // R10 same-cycle conditional stores
      for (int p = 0; p < NP; p++)
         for (int q = p + 1; q < NP; q++) begin
            issue1(p, LL, 3, '0, '0, "R10 link a");
            issue1(q, LL, 3, '0, '0, "R10 link b");
            drive(p, SC, 3, DW'(8'h80 + p));
            drive(q, SC, 3, DW'(8'h90 + q));
            #1;
            chk("R10 winner grant", 32'(req_grant), 32'(1 << p));
            model_step(p, SC, 3, DW'(8'h80 + p), '0, ed, eok);
            @(posedge clk);
            @(negedge clk);
            req_valid[p] = 1'b0;
            chk("R10 winner ok", 32'(rsp_sc_ok), 32'(eok));
            chk("R10 winner expect", 32'(eok), 32'(1));
            #1;
            chk("R10 loser grant", 32'(req_grant), 32'(1 << q));
            model_step(q, SC, 3, DW'(8'h90 + q), '0, ed, eok);
            @(posedge clk);
            @(negedge clk);
            req_valid = '0;
            chk("R10 loser ok", 32'(rsp_sc_ok), 32'(eok));
            chk("R10 loser expect", 32'(eok), 32'(0));
            issue1(q, LD, 3, '0, '0, "R10 mem");
         end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule